// File: doc/BRIEF.md
# Bus-Invert Low-Power Bus Encoder

This block is a transmitter and receiver pair for a parallel data bus. It limits how many bus lines switch on each transfer. When a word is accepted, the transmitter counts how many bit positions differ between that word and the value it last drove onto the bus. If more than half of the lines would change, it drives the complement of the word and raises a separate flip line, so that fewer wires switch.

The receiver XORs every bus line with the flip line and recovers the original word. Both halves share one clock and one active-low reset. A word enters with a valid strobe and is driven onto the bus on the next clock edge. The decoded word appears, with its own valid pulse, one edge after that.

Top module: `bus_invert_link`

## Requirements
- R1: After reset, the bus lines, the flip line, the decoded data and the decoded valid are all zero.
- R2: When in_valid is high and more than W/2 bits of in_data differ from the current bus_lines, the next edge drives bus_lines to the bitwise complement of in_data and bus_flip to 1.
- R3: When in_valid is high and at most W/2 bits differ (exactly W/2 included), the next edge drives bus_lines to in_data unchanged and bus_flip to 0.
- R4: A single transfer never changes more than W/2 of the bus_lines.
- R5: While in_valid is low, bus_lines and bus_flip keep their values.
- R6: Two edges after a word is accepted, out_valid is 1 and out_data equals that word. In any cycle that does not follow a transfer, out_valid is 0.
- R7: Whenever a word has been driven, bus_lines XOR W copies of bus_flip equals the accepted word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both halves |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies in_data for transfer |
| in_data | input | W | Word to send |
| bus_lines | output | W | Encoded bus as driven |
| bus_flip | output | 1 | High when bus_lines carry the complement of the word |
| out_data | output | W | Word recovered by the receiver |
| out_valid | output | 1 | One-cycle pulse marking a new out_data |

## Verification
Assertions check four things on every clock. At most W/2 bus lines change per transfer. The bus and the flip line hold while no word is offered. The encoded pair always decodes to the accepted word. Every accepted word comes out of the receiver two edges later. Only the bench's scenarios can show which way the vote goes, including the tie at exactly W/2 toggles, and that the reference for the vote is the bus as driven rather than the previous raw word. Only they can show the state right after reset and after a reset in mid-run.

// File: rtl/bus_invert_link.sv
module bus_invert_link #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic [W-1:0] bus_lines,
  output logic         bus_flip,
  output logic [W-1:0] out_data,
  output logic         out_valid
);
  localparam int HALF = W / 2;
  localparam int CW   = $clog2(W + 1);

  logic [W-1:0] bus_q, dec_q, delta;
  logic         flip_q, sent_q, oval_q, vote;
  logic [CW-1:0] toggles;

  function automatic logic [CW-1:0] ones(input logic [W-1:0] v);
    logic [CW-1:0] n;
    n = '0;
    for (int i = 0; i < W; i++) n = n + CW'(v[i]);
    return n;
  endfunction

  assign delta   = in_data ^ bus_q;
  assign toggles = ones(delta);
  assign vote    = toggles > CW'(HALF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_q  <= '0;
      flip_q <= 1'b0;
      sent_q <= 1'b0;
    end else begin
      sent_q <= in_valid;
      if (in_valid) begin
        bus_q  <= in_data ^ {W{vote}};
        flip_q <= vote;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_q  <= '0;
      oval_q <= 1'b0;
    end else begin
      oval_q <= sent_q;
      if (sent_q) dec_q <= bus_q ^ {W{flip_q}};
    end
  end

  assign bus_lines = bus_q;
  assign bus_flip  = flip_q;
  assign out_data  = dec_q;
  assign out_valid = oval_q;

  a_r4_toggle_limit: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bus_lines ^ $past(bus_lines)) <= HALF);

  a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(bus_lines) && $stable(bus_flip)));

  a_r7_encode_roundtrip: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((bus_lines ^ {W{bus_flip}}) == $past(in_data)));

  a_r6_receiver_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 (out_valid && out_data == $past(in_data, 2)));
endmodule

// File: tb/sim_bus_invert_link.sv
module sim_bus_invert_link;
  localparam int W = 8;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic [W-1:0] bus_lines, out_data;
  logic bus_flip, out_valid;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bus_invert_link #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .bus_lines(bus_lines), .bus_flip(bus_flip),
    .out_data(out_data), .out_valid(out_valid));

  // {data, expected bus, expected flip}; chained from bus = 0 after reset
  localparam logic [16:0] VEC [10] = '{
    {8'h0F, 8'h0F, 1'b0},  // 4 toggles: tie, no flip (R3)
    {8'hF0, 8'h0F, 1'b1},  // 8 toggles (R2)
    {8'hFF, 8'hFF, 1'b0},  // vs bus 0F: 4 toggles, raw diff would be 4 too
    {8'h01, 8'hFE, 1'b1},  // 7 toggles (R2)
    {8'hFE, 8'hFE, 1'b0},  // vs bus FE: 0 toggles, vs raw 01 would be 8 (R3)
    {8'h00, 8'hFF, 1'b1},  // 7 toggles
    {8'h1F, 8'h1F, 1'b0},  // 3 toggles
    {8'hE3, 8'h1C, 1'b1},  // 6 toggles
    {8'h55, 8'h55, 1'b0},  // 3 toggles
    {8'hAA, 8'h55, 1'b1}   // 8 toggles
  };

  task automatic chk(input string req, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset bus/flip", {bus_flip, bus_lines}, 9'h000);
    chk("R1 reset out", {out_valid, out_data}, 9'h000);
    rst_n = 1'b1;

    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = VEC[i][16:9];
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = ~VEC[i][16:9];
      chk(VEC[i][0] ? "R2 flip encode" : "R3 plain encode",
          {bus_flip, bus_lines}, {VEC[i][0], VEC[i][8:1]});
      chk("R7 decode at bus", {1'b0, bus_lines ^ {W{bus_flip}}}, {1'b0, VEC[i][16:9]});
      chk("R6 out_valid pulse", {8'h00, out_valid}, 9'h000);
      @(negedge clk);
      chk("R6 decoded word", {out_valid, out_data}, {1'b1, VEC[i][16:9]});
      chk("R5 hold while idle", {bus_flip, bus_lines}, {VEC[i][0], VEC[i][8:1]});
    end

    // R5: several idle cycles with wild data, bus 55/flip 1 must hold
    for (int k = 0; k < 4; k++) begin
      in_data = 8'h0F << k;
      @(negedge clk);
      chk("R5 idle hold", {bus_flip, bus_lines}, 9'h155);
      chk("R6 no out_valid when idle", {8'h00, out_valid}, 9'h000);
    end

    // back-to-back: bus 55 -> 0x00 (4 toggles, tie R3) -> 0xFF (8, R2)
    in_valid = 1'b1; in_data = 8'h00;
    @(negedge clk);
    chk("R3 tie back-to-back", {bus_flip, bus_lines}, 9'h000);
    in_data = 8'hFF;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 back-to-back", {bus_flip, bus_lines}, 9'h100);
    chk("R6 first streamed word", {out_valid, out_data}, 9'h100);
    chk("R4 toggle count", {5'd0, 4'($countones(bus_lines ^ 8'h00))}, 9'd0);
    @(negedge clk);
    chk("R6 second streamed word", {out_valid, out_data}, 9'h1FF);

    // R1: reset in mid-run clears everything
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-run reset bus", {bus_flip, bus_lines}, 9'h000);
    chk("R1 mid-run reset out", {out_valid, out_data}, 9'h000);
    rst_n = 1'b1;
    finish_run();
  end
endmodule